// File: doc/BRIEF.md
# UART Receive FIFO and Line Status

This block is the receive-side status path of a 16550-style serial port. A deserializer hands it finished characters with their parity and framing error flags, plus line-level indications: a level that is high while the line has been held low for more than one whole character time, a level that is high while the line rests at logic 1, and a one-cycle pulse when a new start bit is seen. Accepted characters enter a receive FIFO in which every entry keeps its own parity, framing and break flags next to its eight data bits.

A CPU reads two registers through read strobes. Strobing the receive buffer read pops the FIFO head, whose data sits on `rbr_rdata`. Strobing the status read marks that the CPU has consumed the 32-bit status word on `lsr_rdata`, which clears its read-sensitive bits. The per-character error bits are visible only while the character that carried them is at the FIFO head, while a sticky summary bit covers errors anywhere in the FIFO. Two transmit-side levels are sampled so the word also reports transmitter status.

A break-gating state machine makes sure a long break stores exactly one zero character. Its states are ARMED (characters and breaks accepted), IN_BREAK (a break was stored, everything ignored until the line returns to 1) and AWAIT_START (line idle high, waiting for a new start bit). Transitions: ARMED to IN_BREAK when `line_break` is high (the zero character is pushed on that cycle); IN_BREAK to AWAIT_START when `line_mark` is high; AWAIT_START to ARMED on `rx_start`. All other conditions hold the state.

Top module: `uart_rx_lsr`

## Requirements
- R1: After reset every status bit reads 0, the FIFO is empty and `rbr_rdata` is 0.
- R2: Accepted entries leave in arrival order; up to 16 are held; `rbr_rdata` shows the head data (0 when empty); a receive buffer read pops one entry and has no effect on an empty FIFO.
- R3: Status bit 0 (data ready) is 1 exactly when the FIFO holds at least one entry.
- R4: A character or break arriving while the FIFO is full is discarded and sets status bit 1 (overrun) on the next cycle; a status read clears it.
- R5: Status bit 2 (parity error) and bit 3 (framing error) show the flags of the head entry only, and are 0 when the FIFO is empty.
- R6: Status bit 4 (break) shows the head entry's break flag; it is hidden after a status read or after a data character is accepted, and shows again once a pop brings a new head.
- R7: In ARMED a high `line_break` pushes one entry with data 0 and the break flag set; no further entry is accepted (data or break) until `line_mark` and then `rx_start` have been seen.
- R8: Status bit 7 is set on the cycle after an entry with any error flag is accepted; it stays set until a status read made while no error-flagged entry remains in the FIFO.
- R9: Bit 5 is the registered `tx_fifo_empty` and bit 6 the registered AND of `tx_fifo_empty` and `tx_shift_empty`, each one cycle after the inputs.
- R10: Status bits 31 to 8 always read 0.
- R11: When `rx_valid` and `line_break` are high together in ARMED, only the break entry is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Deserializer presents a finished character |
| rx_data | input | 8 | Character data |
| rx_perr | input | 1 | Parity error for the character |
| rx_ferr | input | 1 | Framing error for the character |
| line_break | input | 1 | Line held low longer than one character time |
| line_mark | input | 1 | Line resting at logic 1 |
| rx_start | input | 1 | New start bit detected (pulse) |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| rd_rbr | input | 1 | Receive buffer read strobe (pops head) |
| rd_lsr | input | 1 | Status register read strobe |
| rbr_rdata | output | 8 | Head character data |
| lsr_rdata | output | 32 | Line status word |

## Verification
The assertions assume the deserializer lowers `line_break` before raising `line_mark`, that `rx_start` only follows an idle line, and that the CPU never strobes both register reads in the same cycle. The stimulus drives every input from tasks on the falling edge and holds each strobe for one cycle, and the break sequence always walks through line high and a start pulse before the next character. Under these conditions the summary bit must be set whenever a head error is visible, and no entry may be stored while the gating machine sits in IN_BREAK.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic              brk;
        logic              fe;
        logic              pe;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);

    typedef enum logic [1:0] {
        ST_ARMED       = 2'd0,
        ST_IN_BREAK    = 2'd1,
        ST_AWAIT_START = 2'd2
    } brk_state_t;

    localparam int BIT_DR   = 0;
    localparam int BIT_OE   = 1;
    localparam int BIT_PE   = 2;
    localparam int BIT_FE   = 3;
    localparam int BIT_BI   = 4;
    localparam int BIT_THRE = 5;
    localparam int BIT_TEMT = 6;
    localparam int BIT_FERR = 7;

endpackage

// File: rtl/rxstat_fifo.sv
module rxstat_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 11,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level
);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [WIDTH-1:0] slots [DEPTH];

    // push and pop are already qualified by full/empty in the parent
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slots[g] <= '0;
                end else if (push && (wr_ptr == PTR_W'(g))) begin
                    slots[g] <= wdata;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign head  = slots[rd_ptr];
    assign empty = (level == '0);
    assign full  = (level == LVL_W'(DEPTH));

endmodule

// File: rtl/rxstat_break_fsm.sv
module rxstat_break_fsm
    import rxstat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic       line_break,
    input  logic       line_mark,
    input  logic       rx_start,
    output logic       want_brk,
    output logic       want_data,
    output brk_state_t state
);

    brk_state_t state_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ARMED;
        end else begin
            state <= state_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        state_nxt = state;
        want_brk  = 1'b0;
        want_data = 1'b0;
        unique case (state)
            ST_ARMED: begin
                if (line_break) begin
                    want_brk  = 1'b1;
                    state_nxt = ST_IN_BREAK;
                end else begin
                    want_data = rx_valid;
                end
            end
            ST_IN_BREAK: begin
                if (line_mark) begin
                    state_nxt = ST_AWAIT_START;
                end
            end
            ST_AWAIT_START: begin
                if (rx_start) begin
                    state_nxt = ST_ARMED;
                end
            end
            default: begin
                state_nxt = ST_ARMED;
            end
        endcase
    end

endmodule

// File: rtl/rxstat_lsr.sv
module rxstat_lsr
    import rxstat_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       empty,
    input  logic       head_pe,
    input  logic       head_fe,
    input  logic       head_brk,
    input  logic       push_ok,
    input  logic       push_err,
    input  logic       push_data,
    input  logic       pop_ok,
    input  logic       pop_err,
    input  logic       overrun,
    input  logic       rd_lsr,
    input  logic       tx_fifo_empty,
    input  logic       tx_shift_empty,
    output logic [7:0] status
);

    logic [CNT_W-1:0] err_cnt;
    logic [CNT_W-1:0] err_cnt_nxt;
    logic             oe_q;
    logic             sum_q;
    logic             hide_bi;
    logic             thre_q;
    logic             temt_q;

    always_comb begin
        err_cnt_nxt = err_cnt;
        if (push_ok && push_err) begin
            err_cnt_nxt = err_cnt_nxt + 1'b1;
        end
        if (pop_err) begin
            err_cnt_nxt = err_cnt_nxt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_cnt <= '0;
            oe_q    <= 1'b0;
            sum_q   <= 1'b0;
            hide_bi <= 1'b0;
            thre_q  <= 1'b0;
            temt_q  <= 1'b0;
        end else begin
            err_cnt <= err_cnt_nxt;
            thre_q  <= tx_fifo_empty;
            temt_q  <= tx_fifo_empty & tx_shift_empty;

            if (overrun) begin
                oe_q <= 1'b1;
            end else if (rd_lsr) begin
                oe_q <= 1'b0;
            end

            if (push_ok && push_err) begin
                sum_q <= 1'b1;
            end else if (rd_lsr && (err_cnt_nxt == '0)) begin
                sum_q <= 1'b0;
            end

            if (rd_lsr || push_data) begin
                hide_bi <= 1'b1;
            end else if (pop_ok) begin
                hide_bi <= 1'b0;
            end
        end
    end

    always_comb begin
        status           = '0;
        status[BIT_DR]   = !empty;
        status[BIT_OE]   = oe_q;
        status[BIT_PE]   = !empty && head_pe;
        status[BIT_FE]   = !empty && head_fe;
        status[BIT_BI]   = !empty && head_brk && !hide_bi;
        status[BIT_THRE] = thre_q;
        status[BIT_TEMT] = temt_q;
        status[BIT_FERR] = sum_q;
    end

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
    import rxstat_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_perr,
    input  logic        rx_ferr,
    input  logic        line_break,
    input  logic        line_mark,
    input  logic        rx_start,
    input  logic        tx_fifo_empty,
    input  logic        tx_shift_empty,
    input  logic        rd_rbr,
    input  logic        rd_lsr,
    output logic [7:0]  rbr_rdata,
    output logic [31:0] lsr_rdata
);

    brk_state_t       brk_state;
    logic             want_brk;
    logic             want_data;
    logic             push_try;
    logic             push_ok;
    logic             pop_ok;
    logic             full;
    logic             empty;
    logic [LVL_W-1:0] level;
    rx_entry_t        wentry;
    rx_entry_t        head;
    logic [7:0]       status;

    rxstat_break_fsm u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .line_break (line_break),
        .line_mark  (line_mark),
        .rx_start   (rx_start),
        .want_brk   (want_brk),
        .want_data  (want_data),
        .state      (brk_state)
    );

    always_comb begin
        if (want_brk) begin
            wentry = '{brk: 1'b1, fe: 1'b0, pe: 1'b0, data: '0};
        end else begin
            wentry = '{brk: 1'b0, fe: rx_ferr, pe: rx_perr, data: rx_data};
        end
    end

    assign push_try = want_brk | want_data;
    assign push_ok  = push_try & ~full;
    assign pop_ok   = rd_rbr & ~empty;

    rxstat_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (ENTRY_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push_ok),
        .wdata (wentry),
        .pop   (pop_ok),
        .head  (head),
        .full  (full),
        .empty (empty),
        .level (level)
    );

    rxstat_lsr #(
        .DEPTH (DEPTH)
    ) u_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .empty          (empty),
        .head_pe        (head.pe),
        .head_fe        (head.fe),
        .head_brk       (head.brk),
        .push_ok        (push_ok),
        .push_err       (wentry.brk | wentry.fe | wentry.pe),
        .push_data      (push_ok & want_data),
        .pop_ok         (pop_ok),
        .pop_err        (pop_ok & (head.brk | head.fe | head.pe)),
        .overrun        (push_try & full),
        .rd_lsr         (rd_lsr),
        .tx_fifo_empty  (tx_fifo_empty),
        .tx_shift_empty (tx_shift_empty),
        .status         (status)
    );

    assign rbr_rdata = empty ? 8'h00 : head.data;
    assign lsr_rdata = {24'h0, status};

endmodule

// File: rtl/rxstat_checker.sv
module rxstat_checker
    import rxstat_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [31:0]      lsr_rdata,
    input logic [LVL_W-1:0] level,
    input logic             push_try,
    input logic             push_ok,
    input logic             full,
    input brk_state_t       brk_state
);

    assert_high_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rdata[31:8] == 24'h0);

    assert_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rdata[0] == (level != '0));

    assert_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH));

    assert_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_try && full) |=> lsr_rdata[1]);

    assert_single_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_state != ST_ARMED) |-> !push_ok);

    assert_summary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rdata[2] || lsr_rdata[3]) |-> lsr_rdata[7]);

    assert_temt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rdata[6] |-> lsr_rdata[5]);

endmodule

bind uart_rx_lsr rxstat_checker #(.DEPTH(DEPTH)) i_rxstat_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .lsr_rdata (lsr_rdata),
    .level     (level),
    .push_try  (push_try),
    .push_ok   (push_ok),
    .full      (full),
    .brk_state (brk_state)
);

// File: tb/test_uart_rx_lsr.sv
module test_uart_rx_lsr;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_perr = 1'b0;
    logic        rx_ferr = 1'b0;
    logic        line_break = 1'b0;
    logic        line_mark = 1'b0;
    logic        rx_start = 1'b0;
    logic        tx_fifo_empty = 1'b1;
    logic        tx_shift_empty = 1'b1;
    logic        rd_rbr = 1'b0;
    logic        rd_lsr = 1'b0;
    logic [7:0]  rbr_rdata;
    logic [31:0] lsr_rdata;

    int n_checks = 0;
    int n_fail = 0;

    // bench model, entry = {brk, fe, pe, data}
    logic [10:0] mq [DEPTH];
    int          mcnt = 0;
    int          merr = 0;
    bit          moe = 0, msum = 0, mhide = 0, mthre = 0, mtemt = 0;

    always #2.5 clk = ~clk;

    uart_rx_lsr #(.DEPTH(DEPTH)) i_uart_rx_lsr (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .line_break(line_break),
        .line_mark(line_mark), .rx_start(rx_start),
        .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
        .rd_rbr(rd_rbr), .rd_lsr(rd_lsr),
        .rbr_rdata(rbr_rdata), .lsr_rdata(lsr_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_lsr();
        logic [31:0] v = '0;
        logic [10:0] h = mq[0];
        v[0] = (mcnt > 0);
        v[1] = moe;
        v[2] = (mcnt > 0) && h[8];
        v[3] = (mcnt > 0) && h[9];
        v[4] = (mcnt > 0) && h[10] && !mhide;
        v[5] = mthre;
        v[6] = mtemt;
        v[7] = msum;
        return v;
    endfunction

    task automatic check_all(input string req);
        chk(req, lsr_rdata, exp_lsr());
        chk(req, {24'h0, rbr_rdata}, (mcnt > 0) ? {24'h0, mq[0][7:0]} : 32'h0);
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic m_push(input logic [10:0] e, input bit is_data);
        if (mcnt == DEPTH) begin
            moe = 1;
        end else begin
            mq[mcnt] = e;
            mcnt++;
            if (e[10:8] != 3'b000) begin
                msum = 1;
                merr++;
            end
            if (is_data) mhide = 1;
        end
    endtask

    task automatic send(input logic [7:0] d, input bit pe, input bit fe);
        rx_valid = 1; rx_data = d; rx_perr = pe; rx_ferr = fe;
        m_push({1'b0, fe, pe, d}, 1);
        cycle();
        rx_valid = 0; rx_perr = 0; rx_ferr = 0;
    endtask

    task automatic pop();
        rd_rbr = 1;
        if (mcnt > 0) begin
            if (mq[0][10:8] != 3'b000) merr--;
            for (int k = 0; k < DEPTH - 1; k++) mq[k] = mq[k + 1];
            mcnt--;
            mhide = 0;
        end
        cycle();
        rd_rbr = 0;
    endtask

    task automatic read_lsr();
        rd_lsr = 1;
        moe = 0;
        mhide = 1;
        if (merr == 0) msum = 0;
        cycle();
        rd_lsr = 0;
    endtask

    task automatic set_tx(input bit fe, input bit se);
        tx_fifo_empty = fe; tx_shift_empty = se;
        mthre = fe; mtemt = fe & se;
        cycle();
    endtask

    // full break sequence: one stored zero, long low, idle, start
    task automatic do_break(input int hold);
        line_break = 1;
        m_push(11'h400, 0);
        for (int k = 0; k < hold; k++) cycle();
        line_break = 0;
        line_mark = 1;
        cycle();
        line_mark = 0;
        rx_start = 1;
        cycle();
        rx_start = 0;
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) mq[k] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset", lsr_rdata, 32'h0);
        chk("R1 reset rbr", {24'h0, rbr_rdata}, 32'h0);
        rst_n = 1;
        mthre = 1; mtemt = 1;
        cycle();
        check_all("R9 tx after reset");

        // R9: all transmit level combinations
        for (int t = 0; t < 4; t++) begin
            set_tx(t[1], t[0]);
            chk("R9 tx bits", lsr_rdata, exp_lsr());
        end
        set_tx(1, 1);

        // R2 R3 R5: fill with every flag combination
        for (int i = 0; i < DEPTH; i++) begin
            send(8'(i * 17 + 3), i[0], i[1]);
            check_all("R3 R5 fill");
        end
        // R4: overrun on full, new char discarded
        send(8'hEE, 0, 0);
        check_all("R4 overrun set");
        chk("R10 high zero", {8'h0, lsr_rdata[31:8]}, 32'h0);
        read_lsr();
        check_all("R4 overrun cleared");
        // R2 R5 R8: drain in order
        for (int i = 0; i < DEPTH; i++) begin
            pop();
            check_all("R2 R5 R8 drain");
        end
        pop();
        check_all("R2 pop on empty");
        // R8: summary stays until read with no error entries
        chk("R8 sticky after drain", {31'h0, lsr_rdata[7]}, 32'h1);
        read_lsr();
        check_all("R8 cleared");

        // R8: read while error entry remains keeps bit
        send(8'h55, 0, 1);
        send(8'h66, 0, 0);
        read_lsr();
        check_all("R8 kept while error queued");
        pop();
        read_lsr();
        check_all("R8 clear after error left");
        pop();
        check_all("R3 empty");

        // R6 R7: break stores one zero char
        do_break(5);
        check_all("R7 single break char");
        chk("R6 bi shown", {31'h0, lsr_rdata[4]}, 32'h1);
        read_lsr();
        check_all("R6 bi hidden by read");
        pop();
        check_all("R7 only one entry");

        // R6: data char accepted hides break bit; pop reveals next break
        send(8'h11, 0, 0);
        do_break(2);
        send(8'h22, 0, 0);
        check_all("R6 head normal");
        pop();
        check_all("R6 break revealed at head");
        send(8'h33, 0, 0);
        check_all("R6 hidden by data push");
        pop();
        pop();
        read_lsr();
        check_all("R6 cleanup");

        // R7: input ignored while waiting for idle and start
        line_break = 1;
        m_push(11'h400, 0);
        cycle();
        rx_valid = 1; rx_data = 8'h99;
        cycle();
        rx_valid = 0;
        check_all("R7 data ignored in break");
        line_break = 0; line_mark = 1;
        cycle();
        line_mark = 0; line_break = 1;
        cycle();
        line_break = 0;
        check_all("R7 break ignored awaiting start");
        rx_start = 1;
        cycle();
        rx_start = 0;
        // R11: break wins over simultaneous data
        pop();
        read_lsr();
        line_break = 1; rx_valid = 1; rx_data = 8'h77;
        m_push(11'h400, 0);
        cycle();
        line_break = 0; rx_valid = 0;
        check_all("R11 break priority");
        line_mark = 1;
        cycle();
        line_mark = 0; rx_start = 1;
        cycle();
        rx_start = 0;
        pop();
        check_all("R11 only break stored");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule